// File: doc/BRIEF.md
# Out-of-Order Issue Scheduler

This block is the instruction buffer between dispatch and execution. Dispatch writes one instruction per cycle into a free slot. The write carries an identifier, a target resource group, a set of source-operand tags each with an availability flag, an execution latency, and a resource-cycle count. Each occupied slot is in one of three states: waiting for operands, ready, or issued. A result-broadcast bus carries one producer tag per cycle. Every waiting slot compares its missing source tags against it, and a slot with no missing sources moves to ready.

Each resource group has one issue port and several identical execution units. In each cycle, each group issues the oldest ready slot aimed at it, provided one of its units is free. A round-robin pointer chooses among the group's free units. A unit stays occupied for the instruction's resource-cycle count. An issued slot counts down its latency, raises a completion strobe for the retire logic with its identifier, and then frees itself. Counters record the current, peak and accumulated occupancy, and a histogram records how many cycles saw zero, one, or more issues.

Top module: `ooo_issue_sched`

## Requirements
- R1: At dispatch, a slot becomes ready if every source is flagged available or matches the broadcast tag in that same cycle; otherwise it waits and does not issue.
- R2: A waiting slot becomes ready at the clock edge where a broadcast matches its last missing source, and it can issue in the following cycle. A broadcast that leaves a source missing does not make the slot issuable.
- R3: When several ready slots target one group in the same cycle, the slot dispatched earliest issues first, whatever its slot position. Each group issues at most one slot per cycle.
- R4: An instruction dispatched at clock edge d issues no earlier than the cycle that follows edge d.
- R5: Unit indices run 0 to UNITS-1. A group's pointer starts at 0 and moves to one past the unit it last granted. The pointer's unit is tried first, then the next ones, wrapping around. A unit granted in cycle c with resource count R (0 is treated as 1) is not granted again before cycle c+R.
- R6: A slot issued in cycle c with latency L (0 is treated as 1) raises done_valid with its identifier in cycle c+L. It is free from the next cycle on.
- R7: disp_ready is low exactly when every slot is occupied. A dispatch presented while disp_ready is low is ignored and never issues.
- R8: occ_now is the number of occupied slots. occ_peak is the largest occ_now of any earlier cycle. occ_sum adds occ_now at every clock edge.
- R9: issue_hist[k] counts the cycles in which exactly k groups issued.
- R10: After reset, all slots are free, disp_ready is high, there are no issues or completions, and every counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | At least one slot is free |
| disp_id | input | ID_W | Instruction identifier |
| disp_grp | input | GRP_W | Target resource group |
| disp_src_tag | input | SRCS*TAG_W | Source operand tags |
| disp_src_avail | input | SRCS | Per-source availability at dispatch |
| disp_lat | input | LAT_W | Execution latency in cycles |
| disp_rcyc | input | RC_W | Cycles a unit stays occupied |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| iss_valid | output | GROUPS | Per-group issue strobe |
| iss_unit | output | GROUPS*UIDX_W | Unit chosen in each group |
| iss_id | output | GROUPS*ID_W | Identifier issued in each group |
| done_valid | output | ENTRIES | Per-slot completion strobe to retire |
| done_id | output | ENTRIES*ID_W | Identifier of each completing slot |
| occ_now | output | OCC_W | Current occupied slots |
| occ_peak | output | OCC_W | Peak occupancy seen |
| occ_sum | output | CNT_W | Accumulated occupancy |
| issue_hist | output | (GROUPS+1)*CNT_W | Cycles with k issues, k = 0..GROUPS |

## Verification
The issue outputs depend only on the registered slot and unit state. A dispatch or a final broadcast captured at edge e therefore shows as an issue in the cycle that follows e. The completion for latency L appears L cycles after the issue cycle, and a unit held for R cycles is available again R cycles after its grant. The statistics counters register at the edge that closes each cycle, so they trail the live outputs by one cycle. The bench drives inputs and samples outputs on the falling clock edge, and it counts exactly these offsets before each comparison. The histogram and occupancy totals are compared against an independent per-cycle tally.

// File: rtl/ooo_sched_pkg.sv
// Shared types for the issue scheduler.
package ooo_sched_pkg;

    // Lifecycle of one scheduler slot.
    typedef enum logic [1:0] {
        SLOT_FREE   = 2'd0,
        SLOT_WAIT   = 2'd1,
        SLOT_READY  = 2'd2,
        SLOT_ISSUED = 2'd3
    } slot_state_e;

endpackage

// File: rtl/sched_age_select.sv
// Oldest-first picker for one resource group.
// Assumes older[j][i] = 1 means slot j was dispatched before slot i, and that
// the matrix forms a strict total order over the occupied slots.
module sched_age_select #(
    parameter int N = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N-1:0]          req,
    input  logic [N-1:0][N-1:0]   older,
    output logic [N-1:0]          grant
);

    // Grant a requester that no other requester is older than.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != i && req[j] && older[j][i]) blocked = 1'b1;
            end
            grant[i] = req[i] && !blocked;
        end
    end

    // R3
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R3
    grant_when_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|grant));

endmodule

// File: rtl/sched_unit_pool.sv
// Execution units of one resource group, with a round-robin grant pointer.
// Each unit holds a countdown of remaining busy cycles. Assumes take is raised
// only while any_free is high.
module sched_unit_pool #(
    parameter int UNITS = 2,
    parameter int RC_W  = 2,
    localparam int UIDX_W = (UNITS > 1) ? $clog2(UNITS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [RC_W-1:0]   take_rcyc,
    output logic              any_free,
    output logic [UIDX_W-1:0] pick
);

    logic [RC_W-1:0]   cnt_q [UNITS];
    logic [UIDX_W-1:0] ptr_q;

    // Scan units from the pointer onward and take the first idle one.
    always_comb begin
        int idx;
        any_free = 1'b0;
        pick     = '0;
        for (int k = 0; k < UNITS; k++) begin
            idx = (int'(ptr_q) + k) % UNITS;
            if (!any_free && cnt_q[idx] == '0) begin
                any_free = 1'b1;
                pick     = UIDX_W'(idx);
            end
        end
    end

    // Load the busy countdown of the granted unit and drain the others.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int u = 0; u < UNITS; u++) cnt_q[u] <= '0;
        end else begin
            for (int u = 0; u < UNITS; u++) begin
                if (take && int'(pick) == u)
                    cnt_q[u] <= (take_rcyc == '0) ? '0 : take_rcyc - 1'b1;
                else if (cnt_q[u] != '0)
                    cnt_q[u] <= cnt_q[u] - 1'b1;
            end
        end
    end

    // Move the pointer one past the unit just granted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (take)
            ptr_q <= (int'(pick) == UNITS - 1) ? '0 : pick + 1'b1;
    end

    // R5
    unit_not_rebooked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && take_rcyc > 1) |=> !(take && pick == $past(pick)));

endmodule

// File: rtl/sched_stats.sv
// Occupancy and issue-rate counters. Assumes the counters are wide enough
// for the run length; they wrap silently otherwise.
module sched_stats #(
    parameter int ENTRIES = 4,
    parameter int GROUPS  = 2,
    parameter int CNT_W   = 16,
    localparam int OCC_W  = $clog2(ENTRIES + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ENTRIES-1:0]            busy_mask,
    input  logic [GROUPS-1:0]             iss_vec,
    output logic [OCC_W-1:0]              occ_now,
    output logic [OCC_W-1:0]              occ_peak,
    output logic [CNT_W-1:0]              occ_sum,
    output logic [GROUPS:0][CNT_W-1:0]    issue_hist
);

    int n_iss;

    // Count occupied slots and issuing groups in this cycle.
    always_comb begin
        occ_now = '0;
        for (int i = 0; i < ENTRIES; i++) occ_now = occ_now + OCC_W'(busy_mask[i]);
        n_iss = 0;
        for (int g = 0; g < GROUPS; g++) n_iss = n_iss + int'(iss_vec[g]);
    end

    // Accumulate occupancy, track its peak, and bin the issue count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_peak   <= '0;
            occ_sum    <= '0;
            issue_hist <= '0;
        end else begin
            occ_sum <= occ_sum + CNT_W'(occ_now);
            if (occ_now > occ_peak) occ_peak <= occ_now;
            for (int k = 0; k <= GROUPS; k++)
                if (k == n_iss) issue_hist[k] <= issue_hist[k] + 1'b1;
        end
    end

    // R8
    peak_covers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> occ_peak >= $past(occ_now));

endmodule

// File: rtl/ooo_issue_sched.sv
// Out-of-order issue scheduler: slot storage, operand wakeup, per-group
// oldest-first issue, latency countdown and completion.
// Assumes at most one dispatch and one result broadcast per cycle, and that
// disp_grp is below GROUPS.
module ooo_issue_sched
    import ooo_sched_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int SRCS    = 2,
    parameter int TAG_W   = 4,
    parameter int ID_W    = 4,
    parameter int GROUPS  = 2,
    parameter int UNITS   = 2,
    parameter int LAT_W   = 3,
    parameter int RC_W    = 2,
    parameter int CNT_W   = 16,
    localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int UIDX_W = (UNITS > 1) ? $clog2(UNITS) : 1,
    localparam int OCC_W  = $clog2(ENTRIES + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            disp_valid,
    output logic                            disp_ready,
    input  logic [ID_W-1:0]                 disp_id,
    input  logic [GRP_W-1:0]                disp_grp,
    input  logic [SRCS-1:0][TAG_W-1:0]      disp_src_tag,
    input  logic [SRCS-1:0]                 disp_src_avail,
    input  logic [LAT_W-1:0]                disp_lat,
    input  logic [RC_W-1:0]                 disp_rcyc,
    input  logic                            bc_valid,
    input  logic [TAG_W-1:0]                bc_tag,
    output logic [GROUPS-1:0]               iss_valid,
    output logic [GROUPS-1:0][UIDX_W-1:0]   iss_unit,
    output logic [GROUPS-1:0][ID_W-1:0]     iss_id,
    output logic [ENTRIES-1:0]              done_valid,
    output logic [ENTRIES-1:0][ID_W-1:0]    done_id,
    output logic [OCC_W-1:0]                occ_now,
    output logic [OCC_W-1:0]                occ_peak,
    output logic [CNT_W-1:0]                occ_sum,
    output logic [GROUPS:0][CNT_W-1:0]      issue_hist
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    slot_state_e                  st_q   [ENTRIES];
    logic [ID_W-1:0]              id_q   [ENTRIES];
    logic [GRP_W-1:0]             grp_q  [ENTRIES];
    logic [SRCS-1:0][TAG_W-1:0]   tag_q  [ENTRIES];
    logic [SRCS-1:0]              rdy_q  [ENTRIES];
    logic [LAT_W-1:0]             lat_q  [ENTRIES];
    logic [RC_W-1:0]              rc_q   [ENTRIES];
    logic [ENTRIES-1:0][ENTRIES-1:0] older_q;

    logic                         any_free;
    logic                         disp_fire;
    logic [IDX_W-1:0]             alloc_idx;
    logic [SRCS-1:0]              disp_rdy_now;
    logic [SRCS-1:0]              wake_rdy [ENTRIES];
    logic [GROUPS-1:0][ENTRIES-1:0] req_g;
    logic [GROUPS-1:0][ENTRIES-1:0] grant_g;
    logic [GROUPS-1:0]            unit_free;
    logic [GROUPS-1:0][UIDX_W-1:0] unit_pick;
    logic [GROUPS-1:0][RC_W-1:0]  take_rc;
    logic [ENTRIES-1:0]           issued_now;
    logic [ENTRIES-1:0]           busy_mask;

    // Find the lowest-numbered free slot for the next dispatch.
    always_comb begin
        any_free  = 1'b0;
        alloc_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (st_q[i] == SLOT_FREE) begin
                any_free  = 1'b1;
                alloc_idx = IDX_W'(i);
            end
        end
    end

    assign disp_ready = any_free;
    assign disp_fire  = disp_valid && any_free;

    // Source readiness for incoming and stored slots, including this cycle's broadcast.
    always_comb begin
        for (int s = 0; s < SRCS; s++)
            disp_rdy_now[s] = disp_src_avail[s] || (bc_valid && disp_src_tag[s] == bc_tag);
        for (int i = 0; i < ENTRIES; i++)
            for (int s = 0; s < SRCS; s++)
                wake_rdy[i][s] = rdy_q[i][s] || (bc_valid && tag_q[i][s] == bc_tag);
    end

    // Ready slots request their group's port when a unit is free.
    always_comb begin
        for (int g = 0; g < GROUPS; g++)
            for (int i = 0; i < ENTRIES; i++)
                req_g[g][i] = (st_q[i] == SLOT_READY) && (int'(grp_q[i]) == g) && unit_free[g];
    end

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        sched_age_select #(.N(ENTRIES)) u_sel (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req_g[g]),
            .older (older_q),
            .grant (grant_g[g])
        );

        sched_unit_pool #(.UNITS(UNITS), .RC_W(RC_W)) u_pool (
            .clk       (clk),
            .rst_n     (rst_n),
            .take      (|grant_g[g]),
            .take_rcyc (take_rc[g]),
            .any_free  (unit_free[g]),
            .pick      (unit_pick[g])
        );
    end

    // Route each group's granted slot to its issue port.
    always_comb begin
        for (int g = 0; g < GROUPS; g++) begin
            iss_id[g]  = '0;
            take_rc[g] = '0;
            for (int i = 0; i < ENTRIES; i++) begin
                if (grant_g[g][i]) begin
                    iss_id[g]  = iss_id[g] | id_q[i];
                    take_rc[g] = take_rc[g] | rc_q[i];
                end
            end
            iss_valid[g] = |grant_g[g];
            iss_unit[g]  = unit_pick[g];
        end
    end

    // Per-slot issue, completion and occupancy flags.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            issued_now[i] = 1'b0;
            for (int g = 0; g < GROUPS; g++) issued_now[i] = issued_now[i] | grant_g[g][i];
            done_valid[i] = (st_q[i] == SLOT_ISSUED) && (lat_q[i] <= 1);
            done_id[i]    = done_valid[i] ? id_q[i] : '0;
            busy_mask[i]  = (st_q[i] != SLOT_FREE);
        end
    end

    // Slot state machine: allocate, wake, issue, count down, free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_q[i]  <= SLOT_FREE;
                id_q[i]  <= '0;
                grp_q[i] <= '0;
                tag_q[i] <= '0;
                rdy_q[i] <= '0;
                lat_q[i] <= '0;
                rc_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                unique case (st_q[i])
                    SLOT_FREE: begin
                        if (disp_fire && alloc_idx == IDX_W'(i)) begin
                            id_q[i]  <= disp_id;
                            grp_q[i] <= disp_grp;
                            tag_q[i] <= disp_src_tag;
                            rdy_q[i] <= disp_rdy_now;
                            lat_q[i] <= disp_lat;
                            rc_q[i]  <= disp_rcyc;
                            st_q[i]  <= (&disp_rdy_now) ? SLOT_READY : SLOT_WAIT;
                        end
                    end
                    SLOT_WAIT: begin
                        rdy_q[i] <= wake_rdy[i];
                        if (&wake_rdy[i]) st_q[i] <= SLOT_READY;
                    end
                    SLOT_READY: begin
                        if (issued_now[i]) st_q[i] <= SLOT_ISSUED;
                    end
                    SLOT_ISSUED: begin
                        if (lat_q[i] <= 1) st_q[i] <= SLOT_FREE;
                        else               lat_q[i] <= lat_q[i] - 1'b1;
                    end
                endcase
            end
        end
    end

    // Age matrix: a new slot is younger than every slot already occupied.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older_q <= '0;
        end else if (disp_fire) begin
            for (int j = 0; j < ENTRIES; j++) begin
                older_q[j][alloc_idx] <= (st_q[j] != SLOT_FREE);
                older_q[alloc_idx][j] <= 1'b0;
            end
        end
    end

    sched_stats #(.ENTRIES(ENTRIES), .GROUPS(GROUPS), .CNT_W(CNT_W)) u_stats (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_mask  (busy_mask),
        .iss_vec    (iss_valid),
        .occ_now    (occ_now),
        .occ_peak   (occ_peak),
        .occ_sum    (occ_sum),
        .issue_hist (issue_hist)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot_chk
        // R4
        issue_from_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[i] == SLOT_ISSUED && $past(st_q[i]) != SLOT_ISSUED)
                |-> $past(st_q[i]) == SLOT_READY);

        // R6
        done_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
            done_valid[i] |=> st_q[i] != SLOT_ISSUED);
    end

    // R7
    full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_ready && done_valid == '0) |=> !disp_ready);

endmodule

// File: tb/ooo_issue_sched_tb_top.sv
// Self-checking bench: directed sweeps over latency, group, wakeup order,
// unit occupancy and a full buffer, with expected cycles counted by hand.
module ooo_issue_sched_tb_top;

    localparam int ENTRIES = 4;
    localparam int GROUPS  = 2;
    localparam int UNITS   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 1'b0;
    logic disp_ready;
    logic [3:0] disp_id = '0;
    logic [0:0] disp_grp = '0;
    logic [1:0][3:0] disp_src_tag = '0;
    logic [1:0] disp_src_avail = '0;
    logic [2:0] disp_lat = '0;
    logic [1:0] disp_rcyc = '0;
    logic bc_valid = 1'b0;
    logic [3:0] bc_tag = '0;
    logic [1:0] iss_valid;
    logic [1:0][0:0] iss_unit;
    logic [1:0][3:0] iss_id;
    logic [3:0] done_valid;
    logic [3:0][3:0] done_id;
    logic [2:0] occ_now, occ_peak;
    logic [15:0] occ_sum;
    logic [2:0][15:0] issue_hist;

    int n_chk = 0;
    int n_err = 0;
    int exp_ptr [GROUPS];
    int mon_sum = 0;
    int mon_cyc = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ooo_issue_sched dut_i (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_id(disp_id),
        .disp_grp(disp_grp), .disp_src_tag(disp_src_tag), .disp_src_avail(disp_src_avail),
        .disp_lat(disp_lat), .disp_rcyc(disp_rcyc),
        .bc_valid(bc_valid), .bc_tag(bc_tag),
        .iss_valid(iss_valid), .iss_unit(iss_unit), .iss_id(iss_id),
        .done_valid(done_valid), .done_id(done_id),
        .occ_now(occ_now), .occ_peak(occ_peak), .occ_sum(occ_sum), .issue_hist(issue_hist)
    );

    always @(negedge clk) if (rst_n) begin
        mon_sum += int'(occ_now);
        mon_cyc++;
    end

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic put(input int id, input int g, input int t0, input int a0,
                       input int t1, input int a1, input int lat, input int rc);
        disp_valid = 1'b1;
        disp_id = 4'(id);
        disp_grp = 1'(g);
        disp_src_tag[0] = 4'(t0);
        disp_src_avail[0] = 1'(a0);
        disp_src_tag[1] = 4'(t1);
        disp_src_avail[1] = 1'(a1);
        disp_lat = 3'(lat);
        disp_rcyc = 2'(rc);
    endtask

    task automatic idle();
        disp_valid = 1'b0;
        bc_valid = 1'b0;
    endtask

    task automatic bcast(input int t);
        bc_valid = 1'b1;
        bc_tag = 4'(t);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic int done_has(input int id);
        for (int i = 0; i < ENTRIES; i++)
            if (done_valid[i] && int'(done_id[i]) == id) return 1;
        return 0;
    endfunction

    task automatic check_issue(input string rq, input int g, input int id);
        chk(rq, int'(iss_valid[g]), 1);
        chk(rq, int'(iss_id[g]), id);
        chk(rq, int'(iss_unit[g]), exp_ptr[g]);
        exp_ptr[g] = (exp_ptr[g] + 1) % UNITS;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        exp_ptr[0] = 0;
        exp_ptr[1] = 0;
        repeat (3) @(negedge clk);
        @(posedge clk);
        #2 rst_n = 1'b1;
        tick();

        // R10: reset state
        chk("R10 disp_ready", int'(disp_ready), 1);
        chk("R10 occ_now", int'(occ_now), 0);
        chk("R10 iss_valid", int'(iss_valid), 0);
        chk("R10 done_valid", int'(done_valid), 0);
        chk("R10 occ_peak", int'(occ_peak), 0);
        chk("R10 hist", int'(issue_hist[1]) + int'(issue_hist[2]), 0);

        // R4 R6 R5: latency sweep on both groups, ready at dispatch
        for (int g = 0; g < GROUPS; g++) begin
            for (int lat = 1; lat <= 4; lat++) begin
                put(g * 4 + lat, g, 1, 1, 2, 1, lat, 1);
                tick();
                idle();
                check_issue("R4 issue next cycle", g, g * 4 + lat);
                for (int k = 1; k <= lat; k++) begin
                    tick();
                    chk("R6 done timing", done_has(g * 4 + lat), (k == lat) ? 1 : 0);
                end
                tick();
                chk("R6 slot freed", int'(occ_now), 0);
            end
        end

        // R1: broadcast in the dispatch cycle counts as available
        put(1, 0, 5, 0, 6, 1, 1, 1);
        bcast(5);
        tick();
        idle();
        check_issue("R1 same-cycle capture", 0, 1);
        repeat (2) tick();

        // R1 R2: two missing sources, woken one at a time
        put(2, 1, 8, 0, 9, 0, 1, 1);
        tick();
        idle();
        for (int k = 0; k < 3; k++) begin
            chk("R1 waiting no issue", int'(iss_valid[1]), 0);
            tick();
        end
        bcast(8);
        tick();
        idle();
        chk("R2 partial wakeup", int'(iss_valid[1]), 0);
        bcast(9);
        tick();
        idle();
        check_issue("R2 wakeup issue", 1, 2);
        repeat (2) tick();

        // R3: age beats slot position
        put(3, 0, 9, 0, 0, 1, 1, 1);
        tick();
        put(4, 0, 7, 0, 0, 1, 1, 1);
        tick();
        idle();
        bcast(9);
        tick();
        idle();
        check_issue("R3 first", 0, 3);
        repeat (3) tick();
        put(5, 0, 7, 0, 0, 1, 1, 1);
        tick();
        idle();
        chk("R8 occ_now two", int'(occ_now), 2);
        bcast(7);
        tick();
        idle();
        check_issue("R3 oldest first", 0, 4);
        tick();
        check_issue("R3 younger next", 0, 5);
        repeat (3) tick();

        // R5: unit busy for its resource count
        put(6, 1, 0, 1, 0, 1, 1, 3);
        tick();
        put(7, 1, 0, 1, 0, 1, 1, 3);
        check_issue("R5 first unit", 1, 6);
        tick();
        put(8, 1, 0, 1, 0, 1, 1, 1);
        check_issue("R5 second unit", 1, 7);
        tick();
        idle();
        chk("R5 both units busy", int'(iss_valid[1]), 0);
        tick();
        check_issue("R5 unit reuse", 1, 8);
        repeat (4) tick();

        // R7: fill the buffer and present an extra dispatch
        put(9, 0, 12, 0, 0, 1, 1, 1);
        tick();
        put(10, 0, 12, 0, 0, 1, 1, 1);
        tick();
        put(11, 1, 12, 0, 0, 1, 1, 1);
        tick();
        put(12, 1, 12, 0, 0, 1, 1, 1);
        tick();
        chk("R7 full", int'(disp_ready), 0);
        chk("R8 occ_now full", int'(occ_now), 4);
        put(15, 0, 0, 1, 0, 1, 1, 1);
        for (int k = 0; k < 2; k++) begin
            tick();
            chk("R7 ignored occ", int'(occ_now), 4);
            chk("R7 ignored no issue", int'(iss_valid), 0);
        end
        idle();
        bcast(12);
        tick();
        idle();
        check_issue("R3 grp0 after full", 0, 9);
        check_issue("R3 grp1 after full", 1, 11);
        tick();
        check_issue("R3 grp0 second", 0, 10);
        check_issue("R3 grp1 second", 1, 12);
        for (int k = 0; k < 4; k++) begin
            tick();
            chk("R7 extra never issues", int'(iss_valid), 0);
        end
        chk("R8 occ_peak", int'(occ_peak), 4);

        // R8 R9: accumulated counters
        tick();
        #1;
        chk("R8 occ_sum", int'(occ_sum), mon_sum - int'(occ_now));
        chk("R9 hist one", int'(issue_hist[1]), 16);
        chk("R9 hist two", int'(issue_hist[2]), 2);
        chk("R9 hist zero", int'(issue_hist[0]), mon_cyc - 1 - 18);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule